// File: doc/BRIEF.md
# Byte-Lane Write Control for a Synchronous SRAM

This block is the clocked write-control path of a synchronous SRAM whose data word is split into byte lanes of nine bits (eight data bits plus one parity bit). On each rising clock edge it captures a chip select, an active-low global write, an active-low byte-write enable and one active-low enable per lane. It decodes them into per-lane write strobes and a read-cycle flag for the output path.

A small on-chip array with per-lane write masking is included so that the decoded strobes can be checked end to end. The lane count is a parameter and may be two or four. The address depth is also a parameter.

The write into the array is self-timed. It lands on the edge after the controls are captured, so the surrounding logic never sees a write pulse. A read returns every lane of the addressed word. The read data is presented one edge after the read-cycle flag.

Top module: `bwe_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `wr_strobe_o` is all zeros, `rd_cycle_o` and `rd_valid_o` are 0, and `rdata_o` is zero.
- R2: If `sel_i`=1 and `gw_n_i`=0 at an edge, every bit of `wr_strobe_o` is 1 after that edge, whatever `bw_n_i` and `be_n_i` are.
- R3: If `sel_i`=1, `gw_n_i`=1 and `bw_n_i`=1 at an edge, then after that edge `rd_cycle_o`=1 and `wr_strobe_o` is zero.
- R4: If `sel_i`=1, `gw_n_i`=1, `bw_n_i`=0 and every bit of `be_n_i` is 1 at an edge, the cycle is a read: after that edge `rd_cycle_o`=1 and `wr_strobe_o` is zero.
- R5: If `sel_i`=1, `gw_n_i`=1 and `bw_n_i`=0 at an edge, then after that edge `wr_strobe_o[i]` = ~`be_n_i[i]` for every lane i. Any combination of lanes is allowed. Lane i occupies data bits [9i+8:9i].
- R6: One edge after `rd_cycle_o` is 1, `rd_valid_o`=1 and `rdata_o` holds all lanes of the word at the captured address, whatever `be_n_i` was. When `rd_valid_o`=0, `rdata_o` is zero.
- R7: If `sel_i`=0 at an edge, then after that edge `wr_strobe_o` is zero, `rd_cycle_o`=0, and the array is left unchanged.
- R8: A write changes only the lanes whose strobes are set. The other lanes of the word keep their previous contents.
- R9: A read issued in the cycle right after a write to the same address returns the newly written lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Chip select, active high |
| gw_n_i | input | 1 | Global write, active low: writes all lanes |
| bw_n_i | input | 1 | Byte-write enable, active low |
| be_n_i | input | LANES | Per-lane enables, active low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 9*LANES | Write data, lane i in bits [9i+8:9i] |
| wr_strobe_o | output | LANES | Registered per-lane write strobes |
| rd_cycle_o | output | 1 | Registered read-cycle flag |
| rd_valid_o | output | 1 | Read data valid |
| rdata_o | output | 9*LANES | Read data, all lanes |

## Verification
The strobes and the read-cycle flag are due one edge after the controls are captured. The read data and its valid flag are due one edge later still.

The bench drives each operation on a falling edge and lets one rising edge pass. It then checks the strobes and the read-cycle flag at the next falling edge. At that same falling edge it checks the valid flag and data of the previous operation, against a reference word kept in the bench.

The next operation is driven directly after these checks, so a write followed by a read of the same address lands in the back-to-back timing of R9.

// File: rtl/bwe_pkg.sv
package bwe_pkg;
  localparam int LANE_BITS = 9;

  function automatic int word_bits(input int lanes);
    return lanes * LANE_BITS;
  endfunction
endpackage

// File: rtl/bwe_decode.sv
module bwe_decode #(
  parameter int LANES = 4
) (
  input  logic             sel,
  input  logic             gw_n,
  input  logic             bw_n,
  input  logic [LANES-1:0] be_n,
  output logic [LANES-1:0] lane_we,
  output logic             is_read
);
  always_comb begin
    lane_we = '0;
    if (sel) begin
      if (!gw_n)      lane_we = '1;
      else if (!bw_n) lane_we = ~be_n;
    end
    is_read = sel && (lane_we == '0);
  end
endmodule

// File: rtl/bwe_sample.sv
module bwe_sample #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 4,
  localparam int WORD_W = bwe_pkg::word_bits(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              gw_n,
  input  logic              bw_n,
  input  logic [LANES-1:0]  be_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [LANES-1:0]  wr_q,
  output logic              rd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [WORD_W-1:0] wdata_q
);
  logic [LANES-1:0] we_c;
  logic             rd_c;

  bwe_decode #(.LANES(LANES)) u_dec (
    .sel(sel), .gw_n(gw_n), .bw_n(bw_n), .be_n(be_n),
    .lane_we(we_c), .is_read(rd_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= '0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= we_c;
      rd_q <= rd_c;
    end
    addr_q  <= addr;
    wdata_q <= wdata;
  end
endmodule

// File: rtl/bwe_lane_ram.sv
module bwe_lane_ram #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 4,
  localparam int LB     = bwe_pkg::LANE_BITS,
  localparam int WORD_W = bwe_pkg::word_bits(LANES),
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] dout;
  logic              valid_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LB-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_lanes[g]) mem[addr] <= wdata[g*LB +: LB];
      dout[g*LB +: LB] <= mem[addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= rd_req;
  end

  assign rd_valid = valid_q;
  assign rdata    = valid_q ? dout : '0;
endmodule

// File: rtl/bwe_top.sv
module bwe_top #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 4,
  localparam int WORD_W = bwe_pkg::word_bits(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              gw_n_i,
  input  logic              bw_n_i,
  input  logic [LANES-1:0]  be_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [LANES-1:0]  wr_strobe_o,
  output logic              rd_cycle_o,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;

  bwe_sample #(.LANES(LANES), .ADDR_W(ADDR_W)) u_smp (
    .clk(clk), .rst(rst), .sel(sel_i), .gw_n(gw_n_i), .bw_n(bw_n_i),
    .be_n(be_n_i), .addr(addr_i), .wdata(wdata_i),
    .wr_q(wr_strobe_o), .rd_q(rd_cycle_o), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  bwe_lane_ram #(.LANES(LANES), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .rst(rst), .wr_lanes(wr_strobe_o), .rd_req(rd_cycle_o),
    .addr(addr_q), .wdata(wdata_q), .rd_valid(rd_valid_o), .rdata(rdata_o)
  );
endmodule

// File: rtl/bwe_chk.sv
module bwe_chk #(
  parameter int LANES  = 4,
  parameter int WORD_W = 36
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_i,
  input logic             gw_n_i,
  input logic             bw_n_i,
  input logic [LANES-1:0] be_n_i,
  input logic [LANES-1:0] wr_strobe_o,
  input logic             rd_cycle_o,
  input logic             rd_valid_o,
  input logic [WORD_W-1:0] rdata_o
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (wr_strobe_o == '0 && !rd_cycle_o && !rd_valid_o)); // R1
  AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (rst) (sel_i && !gw_n_i) |=> (wr_strobe_o == '1)); // R2
  AST_BW_OFF_READ: assert property (@(posedge clk) disable iff (rst) (sel_i && gw_n_i && bw_n_i) |=> (rd_cycle_o && wr_strobe_o == '0)); // R3
  AST_NO_LANE_READ: assert property (@(posedge clk) disable iff (rst) (sel_i && gw_n_i && !bw_n_i && (&be_n_i)) |=> rd_cycle_o); // R4
  AST_LANE_MAP: assert property (@(posedge clk) disable iff (rst) (sel_i && gw_n_i && !bw_n_i) |=> (wr_strobe_o == ~$past(be_n_i))); // R5
  AST_READ_VALID: assert property (@(posedge clk) disable iff (rst) rd_cycle_o |=> rd_valid_o); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) !rd_valid_o |-> (rdata_o == '0)); // R6
  AST_DESELECT: assert property (@(posedge clk) disable iff (rst) !sel_i |=> (wr_strobe_o == '0 && !rd_cycle_o)); // R7
endmodule

bind bwe_top bwe_chk #(.LANES(LANES), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .sel_i(sel_i), .gw_n_i(gw_n_i), .bw_n_i(bw_n_i),
  .be_n_i(be_n_i), .wr_strobe_o(wr_strobe_o), .rd_cycle_o(rd_cycle_o),
  .rd_valid_o(rd_valid_o), .rdata_o(rdata_o)
);

// File: tb/sim_bwe_top.sv
module sim_bwe_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 4;
  localparam int ADDR_W = 4;
  localparam int WORD_W = 9 * LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0, gw_n = 1'b1, bw_n = 1'b1;
  logic [LANES-1:0]  be_n = '1;
  logic [ADDR_W-1:0] addr = '0;
  logic [WORD_W-1:0] wdata = '0;
  logic [LANES-1:0]  strobe;
  logic              rdc, rdv;
  logic [WORD_W-1:0] rdata;

  int errors = 0;
  int checks = 0;
  logic [WORD_W-1:0] model [DEPTH];
  logic              pend_rd = 1'b0;
  logic [WORD_W-1:0] pend_exp = '0;
  logic              pend_raw = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bwe_top #(.LANES(LANES), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .sel_i(sel), .gw_n_i(gw_n), .bw_n_i(bw_n),
    .be_n_i(be_n), .addr_i(addr), .wdata_i(wdata),
    .wr_strobe_o(strobe), .rd_cycle_o(rdc), .rd_valid_o(rdv), .rdata_o(rdata)
  );

  task automatic check(input bit ok, input string req, input logic [WORD_W-1:0] act,
                       input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One operation: drive at falling edge, one rising edge, check at next falling edge.
  task automatic op(input logic s, input logic g, input logic b, input logic [LANES-1:0] e,
                    input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d, input bit raw_tag);
    logic [LANES-1:0] exp_we;
    logic exp_rd;
    string tag;
    sel = s; gw_n = g; bw_n = b; be_n = e; addr = a; wdata = d;
    exp_we = '0;
    if (!s)      tag = "R7";
    else if (!g) begin exp_we = '1; tag = "R2"; end
    else if (b)  tag = "R3";
    else if (&e) tag = "R4";
    else begin exp_we = ~e; tag = "R5"; end
    exp_rd = s && (exp_we == '0);
    @(posedge clk);
    @(negedge clk);
    check(strobe == exp_we, tag, WORD_W'(strobe), WORD_W'(exp_we));
    check(rdc == exp_rd, tag, WORD_W'(rdc), WORD_W'(exp_rd));
    // previous operation's read data (R6, R8 lane masking, R9 when flagged)
    check(rdv == pend_rd, "R6", WORD_W'(rdv), WORD_W'(pend_rd));
    if (pend_rd)
      check(rdata == pend_exp, pend_raw ? "R9" : "R6 R8", rdata, pend_exp);
    else
      check(rdata == '0, "R6", rdata, '0);
    pend_rd  = exp_rd;
    pend_exp = model[a];
    pend_raw = raw_tag;
    for (int l = 0; l < LANES; l++)
      if (exp_we[l]) model[a][l*9 +: 9] = d[l*9 +: 9];
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
      end
    end
  end

  initial begin
    logic [WORD_W-1:0] d;
    repeat (3) @(negedge clk);
    check(strobe == '0 && !rdc && !rdv && rdata == '0, "R1", rdata, '0);
    rst = 1'b0;
    @(negedge clk);
    check(strobe == '0 && !rdc && !rdv, "R1", WORD_W'(strobe), '0);

    // fill with global writes, byte controls arbitrary (R2)
    for (int a = 0; a < DEPTH; a++)
      op(1, 0, a[0], LANES'(a), ADDR_W'(a), WORD_W'(a * 36'h3_5A5A_1234 + 36'h1_0F0F), 0);

    // sweep all control combinations over four addresses
    for (int a = 0; a < 4; a++)
      for (int s = 0; s < 2; s++)
        for (int g = 0; g < 2; g++)
          for (int b = 0; b < 2; b++)
            for (int e = 0; e < (1 << LANES); e++) begin
              d = WORD_W'((a * 131 + e * 17 + g * 7 + b * 3 + s) * 36'h2_7D4B_9E3);
              op(s[0], g[0], b[0], LANES'(e), ADDR_W'(a), d, 0);
              // read back after each operation: masking and deselect effects (R7, R8)
              op(1, 1, 1, LANES'(e), ADDR_W'(a), '0, 0);
            end

    // back-to-back write then read of the same address (R9)
    for (int a = 0; a < DEPTH; a++) begin
      op(1, 1, 0, LANES'(a + 1), ADDR_W'(a), WORD_W'(36'hA_BCDE_F012 ^ a), 0);
      op(1, 1, 0, '1, ADDR_W'(a), '0, 1);
    end
    // flush the last pending read
    op(0, 1, 1, '1, '0, '0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule